// File: doc/BRIEF.md
# Square-Wave Counter Channel with Odd-Count Handling

This block is one counting channel that turns a 16-bit count N into a continuous square wave whose period is N count ticks. A count tick is a system clock cycle in which the count-clock enable is high. The channel keeps a 17-bit down-counter that normally drops by two per tick. Each time the counter reaches its terminal count, the output changes level and the counter is refilled with the full count, so each half-period lasts about N/2 ticks.

When N is odd, the first tick after each refill is adjusted. In the high half the counter drops by one, and in the low half it drops by three. As a result the high half lasts one tick longer than the low half.

An external gate pauses and resynchronises the wave. While the gate is low, counting stops and the output is held high. When the gate rises, the half-period starts over from the full count. The gate pin is asynchronous, so it passes through a two-stage synchroniser before the channel uses it. Counts are written through a single strobe with a 16-bit value. A new count written while the wave is running takes effect only at the next refill.

Top module: `sqw_gen`

## Requirements
- R1: After reset the output is high, and it stays high until a valid count is written, whatever the tick and gate inputs do.
- R2: A valid write while idle arms the channel. The full count is N, or 65536 when the written value is 0. The first half-period is high and starts with the next tick.
- R3: For an even N with ticks every cycle and the gate high, the output is high for N/2 cycles and low for N/2 cycles, repeating.
- R4: For an odd N, the first tick after a refill drops the counter by 1 in the high half and by 3 in the low half. Every other tick drops it by 2. The high half lasts (N+1)/2 ticks and the low half (N-1)/2 ticks.
- R5: The counter and the output advance only in cycles where the count-clock enable is high. The output changes level in the cycle right after the terminal tick's clock edge.
- R6: A write of the value 1 is ignored. An idle channel stays idle with its output high, and a running channel keeps its count.
- R7: A count written while running does not change the half-period in progress. The next refill uses the newest count.
- R8: The gate passes through two synchroniser flops. Once the synchronised gate is low, the output is high on the next clock and the counter holds its value.
- R9: A rising edge of the synchronised gate refills the counter with the newest count and restarts a high half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-clock enable, one tick per high cycle |
| gate_in | input | 1 | Asynchronous gate; low pauses the channel, a rising edge restarts it |
| load_stb | input | 1 | Count write strobe |
| load_val | input | 16 | Count value written with the strobe (0 means 65536) |
| wave_out | output | 1 | Square-wave output |

## Verification
On every cycle the assertions check the following:
- an idle channel holds its output high;
- a low synchronised gate forces the output high on the next clock;
- the output only falls in the cycle after a tick;
- an armed counter never sits at zero or above 65536;
- a write of 1 never arms the channel.

Some behaviour can only be shown by the bench's scenarios. These are the exact half-period lengths for even and odd counts, the deferred effect of a write made while running, and the restart phase after a gate rise. They are checked by a cycle-accurate reference model driven by seeded random ticks, gate pulses and writes, together with directed duty-cycle windows.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  // Decrement applied by one tick, chosen from the refill flag, the parity
  // of the full count and the current output level.
  function automatic logic [1:0] step_size(input logic first,
                                           input logic odd,
                                           input logic high);
    if (first && odd) return high ? 2'd1 : 2'd3;
    return 2'd2;
  endfunction
endpackage

// File: rtl/sqw_gate_sync.sv
module sqw_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_s,
  output logic gate_rise
);
  logic [STAGES-1:0] sr_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr_q[0] <= 1'b0;
          else        sr_q[0] <= gate_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr_q[i] <= 1'b0;
          else        sr_q[i] <= sr_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sr_q[STAGES-1];
  end

  assign gate_s    = sr_q[STAGES-1];
  assign gate_rise = sr_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sqw_half_step.sv
module sqw_half_step #(
  parameter int CW = 17
) (
  input  logic [CW-1:0] cnt,
  input  logic          first,
  input  logic          high,
  output logic [CW-1:0] cnt_dec,
  output logic          term
);
  import sqw_pkg::*;
  logic [1:0]    dec;
  logic [CW-1:0] dec_w;

  always_comb begin
    dec     = step_size(first, cnt[0], high);
    dec_w   = {{(CW-2){1'b0}}, dec};
    term    = (cnt <= dec_w);
    cnt_dec = cnt - dec_w;
  end
endmodule

// File: rtl/sqw_gen.sv
module sqw_gen #(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic             wave_out
);
  localparam int CW = CNT_W + 1;

  logic          gate_s, gate_rise;
  logic          armed_q, armed_d;
  logic          first_q, first_d;
  logic          wave_q, wave_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pend_q, pend_d;
  logic [CW-1:0] cnt_dec, val_ext;
  logic          term, load_ok;

  sqw_gate_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in),
    .gate_s(gate_s), .gate_rise(gate_rise)
  );

  sqw_half_step #(.CW(CW)) u_step (
    .cnt(cnt_q), .first(first_q), .high(wave_q),
    .cnt_dec(cnt_dec), .term(term)
  );

  always_comb begin
    val_ext = (load_val == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, load_val};
    load_ok = load_stb && (load_val != {{(CNT_W-1){1'b0}}, 1'b1});
    pend_d  = load_ok ? val_ext : pend_q;
    armed_d = armed_q;
    first_d = first_q;
    wave_d  = wave_q;
    cnt_d   = cnt_q;
    if (!armed_q) begin
      if (load_ok) begin
        armed_d = 1'b1;
        cnt_d   = val_ext;
        first_d = 1'b1;
        wave_d  = 1'b1;
      end
    end else if (!gate_s) begin
      wave_d = 1'b1;
    end else if (gate_rise) begin
      cnt_d   = pend_q;
      first_d = 1'b1;
      wave_d  = 1'b1;
    end else if (tick_en) begin
      if (term) begin
        cnt_d   = pend_q;
        first_d = 1'b1;
        wave_d  = ~wave_q;
      end else begin
        cnt_d   = cnt_dec;
        first_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      first_q <= 1'b0;
      wave_q  <= 1'b1;
      cnt_q   <= '0;
      pend_q  <= '0;
    end else begin
      armed_q <= armed_d;
      first_q <= first_d;
      wave_q  <= wave_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign wave_out = wave_q;
endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk #(
  parameter int CNT_W = 16,
  parameter int CW    = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             load_stb,
  input logic [CNT_W-1:0] load_val,
  input logic             gate_s,
  input logic             armed_q,
  input logic [CW-1:0]    cnt_q,
  input logic             wave_out
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> wave_out);

  assert_gate_forces_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !gate_s) |=> wave_out);

  assert_fall_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wave_out) |-> $past(tick_en));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q != '0 && cnt_q <= {1'b1, {CNT_W{1'b0}}}));

  assert_one_rejected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && load_stb && load_val == {{(CNT_W-1){1'b0}}, 1'b1}) |=> !armed_q);
endmodule

bind sqw_gen sqw_gen_chk #(.CNT_W(CNT_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_stb(load_stb),
  .load_val(load_val), .gate_s(gate_s), .armed_q(armed_q),
  .cnt_q(cnt_q), .wave_out(wave_out)
);

// File: tb/sim_sqw_gen.sv
`timescale 1ns/1ps
module sim_sqw_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate_in = 1'b0;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic        wave_out;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  sqw_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
    .load_stb(load_stb), .load_val(load_val), .wave_out(wave_out)
  );

  // Reference model built from the requirements.
  logic        m_s1, m_s2, m_gq, m_arm, m_first, m_wave;
  logic [16:0] m_cnt, m_pend;
  int          m_dec;

  function automatic logic [16:0] ext(input logic [15:0] v);
    return (v == 16'd0) ? 17'h10000 : {1'b0, v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_gq <= 0; m_arm <= 0; m_first <= 0;
      m_wave <= 1; m_cnt <= 0; m_pend <= 0;
    end else begin
      m_s1 <= gate_in; m_s2 <= m_s1; m_gq <= m_s2;
      if (load_stb && load_val != 16'd1) m_pend <= ext(load_val);
      if (!m_arm) begin
        if (load_stb && load_val != 16'd1) begin
          m_arm <= 1; m_cnt <= ext(load_val); m_first <= 1; m_wave <= 1;
        end
      end else if (!m_s2) begin
        m_wave <= 1;
      end else if (!m_gq) begin
        m_cnt <= m_pend; m_first <= 1; m_wave <= 1;
      end else if (tick_en) begin
        m_dec = (m_first && m_cnt[0]) ? (m_wave ? 1 : 3) : 2;
        if (m_cnt <= 17'(m_dec)) begin
          m_cnt <= m_pend; m_first <= 1; m_wave <= ~m_wave;
        end else begin
          m_cnt <= m_cnt - 17'(m_dec); m_first <= 0;
        end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: wave_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on && rst_n) check(tag, wave_out, m_wave);

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; load_stb = 0; tick_en = 0; gate_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write(input logic [15:0] v);
    @(negedge clk); load_stb = 1; load_val = v;
    @(negedge clk); load_stb = 0;
  endtask

  // R3/R4: in any window of N cycles, high cycles = ceil(N/2).
  task automatic duty(input int n, input string req);
    int highs = 0;
    do_reset(); tick_en = 1; gate_in = 1;
    repeat (4) @(negedge clk);
    write(16'(n));
    repeat (3 * n + 5) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (wave_out) highs++;
      @(negedge clk);
    end
    checks++;
    if (highs != (n + 1) / 2) begin
      fails++;
      $display("FAIL %s: N=%0d high cycles=%0d expected %0d", req, n, highs, (n + 1) / 2);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    do_reset();
    check("R1", wave_out, 1'b1);
    tag = "R1"; model_on = 1;
    tick_en = 1; gate_in = 1;
    repeat (20) @(negedge clk);
    tag = "R6"; write(16'd1);
    repeat (10) @(negedge clk);
    check("R6", wave_out, 1'b1);
    tag = "R2"; write(16'd6);
    repeat (40) @(negedge clk);
    tag = "R7"; write(16'd11);
    repeat (60) @(negedge clk);
    tag = "R6"; write(16'd1);
    repeat (40) @(negedge clk);
    tag = "R8"; gate_in = 0;
    repeat (15) @(negedge clk);
    tag = "R9"; gate_in = 1;
    repeat (30) @(negedge clk);
    tag = "R5";
    for (int c = 0; c < 3000; c++) begin
      tick_en = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 99) < 2) gate_in = ~gate_in;
      if (!gate_in && $urandom_range(0, 9) < 3) gate_in = 1;
      load_stb = ($urandom_range(0, 99) < 3);
      load_val = ($urandom_range(0, 49) == 0) ? 16'd1 : 16'($urandom_range(2, 40));
      @(negedge clk);
    end
    load_stb = 0;
    model_on = 0;
    duty(2, "R3"); duty(8, "R3"); duty(3, "R4"); duty(5, "R4"); duty(13, "R4");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule